// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns a parallel character into an asynchronous serial frame on a single line. A character is written into a holding register from an 8-bit input bus with a one-cycle load strobe. A separate serializer takes the character from the holding register as soon as it is free and sends it out. So the next character can be written while the current one is still on the line, and consecutive frames follow each other with no idle time between them.

The character format comes from static control inputs. They set the number of data bits (5 to 8), whether a parity bit is sent, whether that parity is even or odd, and the length of the stop period (one, one and a half, or two bit times). The clock input is the transmit clock, which runs at sixteen times the bit rate, so every bit lasts sixteen clock cycles. Two status outputs report when the holding register is empty and when the serializer is empty. The block has no connection to any receiver, so a receiver can run alongside it at the same time.

Top module: `serial_frame_tx`

## Requirements
- R1: After a clock edge with `rst_n` low, `txd` is 1 and both `hold_empty` and `shift_empty` are 1.
- R2: A frame begins with a start bit (`txd` = 0) that lasts 16 cycles. The data bits follow, least significant first, each lasting 16 cycles. Their number is 5, 6, 7 or 8 for `word_len_sel` = 00, 01, 10 or 11.
- R3: With `parity_off` = 1, no parity bit is sent, and the stop period follows the last data bit directly.
- R4: With `parity_off` = 0, a 16-cycle parity bit follows the data bits. The count of ones over the selected data bits plus the parity bit is even when `parity_odd` = 0 and odd when `parity_odd` = 1.
- R5: The frame ends with `txd` high for 16 cycles when `stop_sel` = 00, 24 cycles when it is 01, and 32 cycles when it is 10 or 11.
- R6: Bus bits above the selected word length have no effect on `txd`, and they are left out of the parity.
- R7: A cycle with `tx_load` = 1 makes `hold_empty` 0 after that edge. If the serializer is empty, the next edge moves the character into the serializer: `hold_empty` goes to 1, `shift_empty` goes to 0, and the start bit appears.
- R8: When the holding register is full as a frame ends, the next start bit follows the last stop cycle directly, and `shift_empty` stays 0.
- R9: When `tx_load` arrives in the same cycle that the held character moves into the serializer, the old held character is sent and the new one stays held.
- R10: Loading while the holding register is already full and the serializer is busy replaces the held character. Only the last one written is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock, 16 times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_data | input | 8 | Character to be sent |
| tx_load | input | 1 | One-cycle strobe that writes `tx_data` into the holding register |
| word_len_sel | input | 2 | Number of data bits: 00=5, 01=6, 10=7, 11=8 |
| parity_off | input | 1 | 1 leaves the parity bit out |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even |
| stop_sel | input | 2 | Stop period: 00=1, 01=1.5, 10 or 11=2 bit times |
| txd | output | 1 | Serial line, high when idle |
| hold_empty | output | 1 | Holding register has no character |
| shift_empty | output | 1 | Serializer has no frame in progress |

## Verification
Two events can fall in the same cycle: the holding register being refilled from the bus, and its previous content moving into the serializer at the end of a frame. The bench provokes this by watching its own model of the line. It pulses the load strobe exactly in the final stop cycle of a frame while a second character is waiting. It then judges the result cycle by cycle: the waiting character must be the one that starts with no gap, and the newly loaded one must follow it as the next frame. Back-to-back frames and overwrites of a full holding register are exercised in the same way.

// File: rtl/sft_pkg.sv
// Package: shared format encodings and helpers for the serial transmitter.
// Assumes the transmit clock is an oversampling clock of OS cycles per bit.
package sft_pkg;

    // Encoding of the stop-period select input
    typedef enum logic [1:0] {
        STOP_ONE      = 2'b00,
        STOP_ONE_HALF = 2'b01,
        STOP_TWO      = 2'b10,
        STOP_TWO_ALT  = 2'b11
    } stop_sel_e;

    // Number of high cycles in the stop period for a given select value
    function automatic int stop_cycles(input stop_sel_e sel, input int os);
        case (sel)
            STOP_ONE:      return os;
            STOP_ONE_HALF: return os + os / 2;
            default:       return 2 * os;
        endcase
    endfunction

    // Width of a counter that holds the longest frame in cycles
    function automatic int tick_width(input int data_w, input int os);
        return $clog2(os * (data_w + 4) + 1);
    endfunction

endpackage

// File: rtl/sft_holding.sv
// Holding register: keeps one character that was written from the bus until
// the serializer takes it. A write has priority over a take in the same
// cycle. The take uses the old content combinationally in that cycle, so
// the new character stays held.
module sft_holding #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              take,
    output logic [DATA_W-1:0] held,
    output logic              full
);

    // Capture a written character and track whether one is waiting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            held <= '0;
        end else if (load) begin
            full <= 1'b1;
            held <= load_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/sft_frame_pack.sv
// Frame packer: builds the bit image of one frame from a character and the
// static format inputs, and computes how many clock cycles the frame lasts.
// Bit 0 of the image is the start bit. The data bits follow LSB first, then
// the optional parity bit. All higher positions are filled with ones, so the
// stop period is produced simply by shifting in ones.
module sft_frame_pack #(
    parameter int DATA_W = 8,
    parameter int WL_MIN = 5,
    parameter int OS     = 16,
    localparam int FW    = DATA_W + 2,
    localparam int TW    = sft_pkg::tick_width(DATA_W, OS)
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        wl_sel,
    input  logic              parity_off,
    input  logic              parity_odd,
    input  logic [1:0]        stop_sel,
    output logic [FW-1:0]     frame,
    output logic [TW-1:0]     frame_cycles
);
    import sft_pkg::*;

    int                nbits;
    int                slots;
    int                total;
    logic [DATA_W-1:0] masked;
    logic              par_bit;

    // Mask the unused bits, compute parity and lay out the frame image
    always_comb begin
        nbits = WL_MIN + int'(wl_sel);
        if (nbits > DATA_W) nbits = DATA_W;
        masked = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nbits) masked[i] = data[i];
        end
        par_bit = (^masked) ^ parity_odd;
        frame = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nbits) frame[i+1] = masked[i];
        end
        if (!parity_off) frame[nbits+1] = par_bit;
        slots = 1 + nbits + (parity_off ? 0 : 1);
        total = slots * OS + stop_cycles(stop_sel_e'(stop_sel), OS);
        frame_cycles = TW'(total);
    end

endmodule

// File: rtl/sft_serializer.sv
// Serializer: shifts a frame image out one bit every OS cycles and counts
// down the total length of the frame in cycles. Assumes that the start
// input arrives only when near_end is high. A start in the last cycle of
// a frame begins the next frame with no gap. The line shows bit 0 of the
// shift register, which holds all ones whenever no frame is running.
module sft_serializer #(
    parameter int DATA_W = 8,
    parameter int OS     = 16,
    localparam int FW    = DATA_W + 2,
    localparam int TW    = sft_pkg::tick_width(DATA_W, OS),
    localparam int PW    = $clog2(OS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [FW-1:0] frame,
    input  logic [TW-1:0] frame_cycles,
    output logic          line,
    output logic          idle,
    output logic          near_end
);

    logic [FW-1:0] shreg;
    logic [TW-1:0] left;
    logic [PW-1:0] phase;

    // Load a new frame, or advance the bit phase and shift at each bit end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '1;
            left  <= '0;
            phase <= '0;
        end else if (start) begin
            shreg <= frame;
            left  <= frame_cycles;
            phase <= '0;
        end else if (left != '0) begin
            left <= left - TW'(1);
            if (phase == PW'(OS - 1)) begin
                phase <= '0;
                shreg <= {1'b1, shreg[FW-1:1]};
            end else begin
                phase <= phase + PW'(1);
            end
        end
    end

    // Line level and the end-of-frame status
    always_comb begin
        line     = shreg[0];
        idle     = (left == '0);
        near_end = (left <= TW'(1));
    end

endmodule

// File: rtl/serial_frame_tx.sv
// Top: asynchronous serial transmitter with a holding register ahead of a
// serializer. The clock is the 16x transmit clock. The format inputs are
// assumed to stay unchanged while a character is held or being sent.
module serial_frame_tx #(
    parameter int DATA_W = 8,
    parameter int WL_MIN = 5,
    parameter int OS     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_load,
    input  logic [1:0]        word_len_sel,
    input  logic              parity_off,
    input  logic              parity_odd,
    input  logic [1:0]        stop_sel,
    output logic              txd,
    output logic              hold_empty,
    output logic              shift_empty
);
    localparam int FW = DATA_W + 2;
    localparam int TW = sft_pkg::tick_width(DATA_W, OS);

    logic [DATA_W-1:0] held;
    logic              held_full;
    logic              take;
    logic [FW-1:0]     frame;
    logic [TW-1:0]     frame_cycles;
    logic              ser_idle;
    logic              ser_near_end;

    // Move the held character when the serializer is idle or in its last cycle
    always_comb take = held_full && ser_near_end;

    sft_holding #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_load),
        .load_data (tx_data),
        .take      (take),
        .held      (held),
        .full      (held_full)
    );

    sft_frame_pack #(.DATA_W(DATA_W), .WL_MIN(WL_MIN), .OS(OS)) u_pack (
        .data         (held),
        .wl_sel       (word_len_sel),
        .parity_off   (parity_off),
        .parity_odd   (parity_odd),
        .stop_sel     (stop_sel),
        .frame        (frame),
        .frame_cycles (frame_cycles)
    );

    sft_serializer #(.DATA_W(DATA_W), .OS(OS)) u_ser (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (take),
        .frame        (frame),
        .frame_cycles (frame_cycles),
        .line         (txd),
        .idle         (ser_idle),
        .near_end     (ser_near_end)
    );

    // Status outputs
    always_comb begin
        hold_empty  = !held_full;
        shift_empty = ser_idle;
    end

endmodule

// File: rtl/sft_checker.sv
// Checker: temporal properties of the transmitter's ports, bound to the top.
module sft_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_load,
    input logic txd,
    input logic hold_empty,
    input logic shift_empty
);
    logic rst_seen = 1'b0;

    // Remember whether the previous edge saw reset asserted
    always_ff @(posedge clk) rst_seen <= !rst_n;

    // R1
    always_ff @(posedge clk) begin
        if (rst_seen) begin
            reset_state_chk: assert (txd && hold_empty && shift_empty);
        end
    end

    // R2
    start_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shift_empty) |-> !txd);

    // R7
    load_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> !hold_empty);

    // R7
    transfer_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_empty && shift_empty && !tx_load) |=> (hold_empty && !shift_empty && !txd));

    // R8
    no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_empty && !shift_empty) |=> !shift_empty);

    // R8
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> txd);

endmodule

bind serial_frame_tx sft_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_load     (tx_load),
    .txd         (txd),
    .hold_empty  (hold_empty),
    .shift_empty (shift_empty)
);

// File: tb/sim_serial_frame_tx.sv
module sim_serial_frame_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_load = 1'b0;
    logic [1:0] word_len_sel = 2'b11;
    logic       parity_off = 1'b1;
    logic       parity_odd = 1'b0;
    logic [1:0] stop_sel = 2'b00;
    logic       txd, hold_empty, shift_empty;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit chk_en = 1'b0;
    bit done = 1'b0;
    string cur_req = "R1";

    // reference model state
    bit   m_q[$];
    bit   m_full = 1'b0;
    logic [7:0] m_data = '0;

    always #5 clk = ~clk;

    serial_frame_tx u0 (
        .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_load(tx_load),
        .word_len_sel(word_len_sel), .parity_off(parity_off), .parity_odd(parity_odd),
        .stop_sel(stop_sel), .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty)
    );

    // append one frame, tick by tick, to the model line
    task automatic push_frame(input logic [7:0] d);
        int n = 5 + int'(word_len_sel);
        int ones = 0;
        int stop_len;
        for (int k = 0; k < 16; k++) m_q.push_back(1'b0);
        for (int b = 0; b < n; b++) begin
            ones += int'(d[b]);
            for (int k = 0; k < 16; k++) m_q.push_back(d[b]);
        end
        if (!parity_off) begin
            bit p = ((ones % 2) == 1) ^ parity_odd;
            for (int k = 0; k < 16; k++) m_q.push_back(p);
        end
        stop_len = (stop_sel == 2'b00) ? 16 : (stop_sel == 2'b01) ? 24 : 32;
        for (int k = 0; k < stop_len; k++) m_q.push_back(1'b1);
    endtask

    // model update at each rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_q.delete();
            m_full = 1'b0;
        end else begin
            if (m_q.size() > 0) void'(m_q.pop_front());
            if (m_q.size() == 0 && m_full) begin
                push_frame(m_data);
                m_full = 1'b0;
            end
            if (tx_load) begin
                m_data = tx_data;
                m_full = 1'b1;
            end
        end
    end

    task automatic check1(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", cur_req, what, act, exp, cycles);
        end
    endtask

    // compare with the model away from the active edge
    always @(negedge clk) begin
        if (chk_en) begin
            check1("txd", txd, (m_q.size() > 0) ? m_q[0] : 1'b1);
            check1("hold_empty", hold_empty, !m_full);
            check1("shift_empty", shift_empty, m_q.size() == 0);
        end
    end

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL %s watchdog expired actual=%0d expected<150000", cur_req, cycles);
            summary();
        end
    end

    task automatic send(input logic [7:0] d);
        @(negedge clk);
        tx_data = d;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    task automatic wait_idle;
        do @(negedge clk); while (m_q.size() != 0 || m_full);
        @(negedge clk);
    endtask

    task automatic fmt(input logic [1:0] wl, input logic poff, input logic podd, input logic [1:0] st);
        word_len_sel = wl;
        parity_off   = poff;
        parity_odd   = podd;
        stop_sel     = st;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        check1("txd", txd, 1'b1);
        check1("hold_empty", hold_empty, 1'b1);
        check1("shift_empty", shift_empty, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        chk_en = 1'b1;

        // R2: word lengths, no parity, one stop bit
        cur_req = "R2";
        for (int wl = 0; wl < 4; wl++) begin
            fmt(2'(wl), 1'b1, 1'b0, 2'b00);
            send(8'h96 ^ 8'(wl));
            wait_idle();
        end

        // R3: parity inhibited, with each stop period
        cur_req = "R3";
        for (int st = 0; st < 4; st++) begin
            fmt(2'b01, 1'b1, 1'b1, 2'(st));
            send(8'h2D);
            wait_idle();
        end

        // R4: even and odd parity at each word length
        cur_req = "R4";
        for (int wl = 0; wl < 4; wl++) begin
            for (int po = 0; po < 2; po++) begin
                fmt(2'(wl), 1'b0, 1'(po), 2'b00);
                send(8'h5B + 8'(wl * 7 + po));
                wait_idle();
            end
        end

        // R5: stop periods 16, 24, 32, 32 cycles
        cur_req = "R5";
        for (int st = 0; st < 4; st++) begin
            fmt(2'b11, 1'b0, 1'b0, 2'(st));
            send(8'hC3);
            send(8'h3C);
            wait_idle();
        end

        // R6: upper bits ignored, parity over selected bits only
        cur_req = "R6";
        fmt(2'b00, 1'b0, 1'b0, 2'b00);
        send(8'hE5);
        wait_idle();
        send(8'h05);
        wait_idle();

        // R7: load from idle, transfer timing
        cur_req = "R7";
        fmt(2'b10, 1'b0, 1'b1, 2'b01);
        send(8'h71);
        wait_idle();

        // R8: back-to-back frames with 1.5 stop bits
        cur_req = "R8";
        send(8'hA1);
        send(8'hB2);
        do @(negedge clk); while (!m_full && m_q.size() != 0);
        send(8'hC3);
        wait_idle();

        // R9: load coincident with the transfer at frame end
        cur_req = "R9";
        fmt(2'b11, 1'b1, 1'b0, 2'b00);
        send(8'h11);
        send(8'h22);
        do @(negedge clk); while (m_q.size() != 1);
        tx_data = 8'h33;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        wait_idle();

        // R10: overwrite of a full holding register while busy
        cur_req = "R10";
        send(8'h44);
        send(8'h55);
        send(8'h66);
        wait_idle();

        // R1: reset mid-frame returns to idle
        cur_req = "R1";
        send(8'h0F);
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        done = 1'b1;
        summary();
    end
endmodule